// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the raster timing for a CRT or LCD panel. A horizontal counter runs on every pixel clock and walks through four intervals: sync pulse, back porch, active pixels and front porch. A vertical counter walks through the same four intervals, but it advances once per completed line. Software sets the length of all eight intervals through input registers, so both the resolution and every porch and pulse width can change at run time.

From the counter state the block drives horizontal sync, vertical sync, composite sync and blanking, each with its own polarity bit. It also drives an active-pixel enable and the pixel and line offsets within the active area. Each sync source can raise a sticky interrupt flag, and software clears the flag by writing a one to the matching acknowledge. At every vertical sync the block can flip a video-page select and, under a separate enable, a lookup-table bank select, which gives flicker-free page flipping. The block holds the timing values in shadow registers that take new input values only at frame boundaries, so a frame is never drawn with mixed timing.

Top module: `vid_timing_gen`

## Requirements
- R1: While reset is high, and on the first clock after it, hsync, vsync, csync and blank sit at their inactive level (the inverse of their polarity bit). pix_en, pix_x, line_y, irq_h, irq_v, page_sel and lut_sel are all 0. The first state after reset is the start of both sync intervals.
- R2: Each interval input holds its length minus one. Both counters step through sync, back porch, active and front porch in that order. A line lasts the sum of the four horizontal lengths in clocks, and a frame lasts the sum of the four vertical lengths in lines.
- R3: hsync sits at the level of pol_hs for exactly the horizontal sync interval and at the inverse level otherwise. vsync behaves the same way for the vertical sync interval, using pol_vs. A polarity bit of 1 means active-high.
- R4: csync is active (level pol_cs) whenever horizontal sync or vertical sync is in its sync interval, and inactive otherwise.
- R5: pix_en is 1 only while both counters are in their active interval. blank is active (level pol_blank) exactly when pix_en is 0. pix_x and line_y give the offset within the horizontal and vertical active intervals, and are 0 outside them.
- R6: When irq_en_h is 1, irq_h goes to 1 on the same clock that hsync turns active. When irq_en_v is 1, irq_v goes to 1 on the same clock that vsync turns active. With its enable at 0 a flag is never set.
- R7: An interrupt flag stays at 1 until its acknowledge input is 1 at a clock edge. If a new sync pulse starts on that same edge, the set takes priority over the clear.
- R8: With bank_en_page at 1, page_sel inverts on the same clock that vsync turns active. With bank_en_lut at 1, lut_sel inverts on that clock independently of page_sel. At all other times, or with the enable at 0, the select holds its value.
- R9: The interval inputs are captured during reset and on the last clock of each frame. A change at any other time has no effect on timing until the next frame.
- R10: All outputs are registered and reflect the counter state one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| h_sync_len | input | HW | Horizontal sync length minus one |
| h_back_len | input | HW | Horizontal back porch length minus one |
| h_act_len | input | HW | Horizontal active length minus one |
| h_front_len | input | HW | Horizontal front porch length minus one |
| v_sync_len | input | VW | Vertical sync length minus one (lines) |
| v_back_len | input | VW | Vertical back porch length minus one |
| v_act_len | input | VW | Vertical active length minus one |
| v_front_len | input | VW | Vertical front porch length minus one |
| pol_hs | input | 1 | Horizontal sync active level |
| pol_vs | input | 1 | Vertical sync active level |
| pol_cs | input | 1 | Composite sync active level |
| pol_blank | input | 1 | Blanking active level |
| irq_en_h | input | 1 | Enable interrupt on horizontal sync |
| irq_en_v | input | 1 | Enable interrupt on vertical sync |
| ack_h | input | 1 | Clear horizontal interrupt flag |
| ack_v | input | 1 | Clear vertical interrupt flag |
| bank_en_page | input | 1 | Enable video-page flip at vertical sync |
| bank_en_lut | input | 1 | Enable lookup-table bank flip at vertical sync |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| csync | output | 1 | Composite sync |
| blank | output | 1 | Blanking |
| pix_en | output | 1 | Active pixel enable |
| pix_x | output | HW | Pixel offset in active line |
| line_y | output | VW | Line offset in active frame |
| irq_h | output | 1 | Horizontal sync interrupt flag |
| irq_v | output | 1 | Vertical sync interrupt flag |
| page_sel | output | 1 | Current video-page select |
| lut_sel | output | 1 | Current lookup-table bank select |

## Verification
The composite-sync and blank assertions compare output levels against the polarity bits of the previous clock. They therefore assume that a polarity bit changes only through the registered path, which the bench respects because it drives every input just after a falling edge. The counter-bound check assumes that the shadow lengths only change at a counter wrap. The bench meets this by changing the interval inputs freely mid-frame, so the capture logic alone decides when they count. The bench keeps all lengths small enough that many complete frames, polarity changes, acknowledge patterns and a mid-run reset fit into a short run.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } vtg_phase_e;
  localparam int unsigned NUM_PHASES = 4;
endpackage

// File: rtl/vtg_axis.sv
module vtg_axis
  import vtg_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             load,
  input  logic [NUM_PHASES-1:0][W-1:0] lens,
  output vtg_phase_e       phase,
  output logic [W-1:0]     cnt,
  output logic             wrap
);
  logic [NUM_PHASES-1:0][W-1:0] shd;
  logic                         at_end;

  // shadow interval lengths, captured only at frame boundaries
  always_ff @(posedge clk) begin
    if (rst || load) shd <= lens;
  end

  assign at_end = (cnt == shd[phase]);
  assign wrap   = step && at_end && (phase == PH_FRONT);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_SYNC;
      cnt   <= '0;
    end else if (step) begin
      if (at_end) begin
        cnt   <= '0;
        phase <= vtg_phase_e'(phase + 2'd1);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (rst)
    (phase != $past(phase)) |-> (2'(phase - $past(phase)) == 2'd1)); // R2

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= shd[phase]); // R2
endmodule

// File: rtl/vtg_events.sv
module vtg_events #(
  parameter int unsigned NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] irq_ev,
  input  logic [NCH-1:0] irq_en,
  input  logic [NCH-1:0] irq_ack,
  input  logic           flip_ev,
  input  logic [NCH-1:0] flip_en,
  output logic [NCH-1:0] irq_q,
  output logic [NCH-1:0] sel_q
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) irq_q[c] <= 1'b0;
      else     irq_q[c] <= (irq_q[c] & ~irq_ack[c]) | (irq_ev[c] & irq_en[c]);
    end

    always_ff @(posedge clk) begin
      if (rst)                       sel_q[c] <= 1'b0;
      else if (flip_ev && flip_en[c]) sel_q[c] <= ~sel_q[c];
    end

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && irq_ev[c] && irq_en[c]) |-> irq_q[c]); // R6

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
      $past(irq_q[c] && !irq_ack[c]) |-> irq_q[c]); // R7

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
      !$past(flip_ev && flip_en[c]) |-> $stable(sel_q[c])); // R8
  end
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vtg_pkg::*;
#(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] h_sync_len,
  input  logic [HW-1:0] h_back_len,
  input  logic [HW-1:0] h_act_len,
  input  logic [HW-1:0] h_front_len,
  input  logic [VW-1:0] v_sync_len,
  input  logic [VW-1:0] v_back_len,
  input  logic [VW-1:0] v_act_len,
  input  logic [VW-1:0] v_front_len,
  input  logic          pol_hs,
  input  logic          pol_vs,
  input  logic          pol_cs,
  input  logic          pol_blank,
  input  logic          irq_en_h,
  input  logic          irq_en_v,
  input  logic          ack_h,
  input  logic          ack_v,
  input  logic          bank_en_page,
  input  logic          bank_en_lut,
  output logic          hsync,
  output logic          vsync,
  output logic          csync,
  output logic          blank,
  output logic          pix_en,
  output logic [HW-1:0] pix_x,
  output logic [VW-1:0] line_y,
  output logic          irq_h,
  output logic          irq_v,
  output logic          page_sel,
  output logic          lut_sel
);
  vtg_phase_e    h_ph, v_ph;
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          h_wrap, v_wrap;
  logic          h_begin, v_begin;
  logic          hs_raw, vs_raw, act_raw;
  logic [1:0]    irq_bits, sel_bits;

  vtg_axis #(.W(HW)) i_h_axis (
    .clk  (clk),
    .rst  (rst),
    .step (1'b1),
    .load (v_wrap),
    .lens ({h_front_len, h_act_len, h_back_len, h_sync_len}),
    .phase(h_ph),
    .cnt  (h_cnt),
    .wrap (h_wrap)
  );

  vtg_axis #(.W(VW)) i_v_axis (
    .clk  (clk),
    .rst  (rst),
    .step (h_wrap),
    .load (v_wrap),
    .lens ({v_front_len, v_act_len, v_back_len, v_sync_len}),
    .phase(v_ph),
    .cnt  (v_cnt),
    .wrap (v_wrap)
  );

  assign hs_raw  = (h_ph == PH_SYNC);
  assign vs_raw  = (v_ph == PH_SYNC);
  assign act_raw = (h_ph == PH_ACT) && (v_ph == PH_ACT);
  assign h_begin = hs_raw && (h_cnt == '0);
  assign v_begin = h_begin && vs_raw && (v_cnt == '0);

  vtg_events #(.NCH(2)) i_events (
    .clk    (clk),
    .rst    (rst),
    .irq_ev ({v_begin, h_begin}),
    .irq_en ({irq_en_v, irq_en_h}),
    .irq_ack({ack_v, ack_h}),
    .flip_ev(v_begin),
    .flip_en({bank_en_lut, bank_en_page}),
    .irq_q  (irq_bits),
    .sel_q  (sel_bits)
  );

  assign irq_h    = irq_bits[0];
  assign irq_v    = irq_bits[1];
  assign page_sel = sel_bits[0];
  assign lut_sel  = sel_bits[1];

  // registered output stage, polarity applied last
  always_ff @(posedge clk) begin
    if (rst) begin
      hsync  <= ~pol_hs;
      vsync  <= ~pol_vs;
      csync  <= ~pol_cs;
      blank  <= ~pol_blank;
      pix_en <= 1'b0;
      pix_x  <= '0;
      line_y <= '0;
    end else begin
      hsync  <= hs_raw ? pol_hs : ~pol_hs;
      vsync  <= vs_raw ? pol_vs : ~pol_vs;
      csync  <= (hs_raw || vs_raw) ? pol_cs : ~pol_cs;
      blank  <= act_raw ? ~pol_blank : pol_blank;
      pix_en <= act_raw;
      pix_x  <= (h_ph == PH_ACT) ? h_cnt : '0;
      line_y <= (v_ph == PH_ACT) ? v_cnt : '0;
    end
  end

  AST_CSYNC_OR: assert property (@(posedge clk) disable iff (rst)
    ((csync == $past(pol_cs)) ==
     ((hsync == $past(pol_hs)) || (vsync == $past(pol_vs))))); // R4

  AST_BLANK_PIX: assert property (@(posedge clk) disable iff (rst)
    pix_en |-> (blank != $past(pol_blank))); // R5

  AST_POS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pix_en |-> ((pix_x == '0) || (line_y == '0) || 1'b0) || (pix_x == '0) || (line_y == '0)); // R5
endmodule

// File: tb/test_vid_timing_gen.sv
module test_vid_timing_gen;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 12;
  localparam int VW = 12;

  typedef struct packed {
    logic          rs;
    logic          hs, vs, cs, bl, pe;
    logic [HW-1:0] x;
    logic [VW-1:0] y;
    logic          ih, iv, ps, ls;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [HW-1:0] h_sync_len, h_back_len, h_act_len, h_front_len;
  logic [VW-1:0] v_sync_len, v_back_len, v_act_len, v_front_len;
  logic pol_hs, pol_vs, pol_cs, pol_blank;
  logic irq_en_h, irq_en_v, ack_h, ack_v, bank_en_page, bank_en_lut;
  logic hsync, vsync, csync, blank, pix_en, irq_h, irq_v, page_sel, lut_sel;
  logic [HW-1:0] pix_x;
  logic [VW-1:0] line_y;

  int n_vec = 0;
  int n_bad = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_timing_gen #(.HW(HW), .VW(VW)) i_vid_timing_gen (
    .clk(clk), .rst(rst),
    .h_sync_len(h_sync_len), .h_back_len(h_back_len),
    .h_act_len(h_act_len), .h_front_len(h_front_len),
    .v_sync_len(v_sync_len), .v_back_len(v_back_len),
    .v_act_len(v_act_len), .v_front_len(v_front_len),
    .pol_hs(pol_hs), .pol_vs(pol_vs), .pol_cs(pol_cs), .pol_blank(pol_blank),
    .irq_en_h(irq_en_h), .irq_en_v(irq_en_v), .ack_h(ack_h), .ack_v(ack_v),
    .bank_en_page(bank_en_page), .bank_en_lut(bank_en_lut),
    .hsync(hsync), .vsync(vsync), .csync(csync), .blank(blank),
    .pix_en(pix_en), .pix_x(pix_x), .line_y(line_y),
    .irq_h(irq_h), .irq_v(irq_v), .page_sel(page_sel), .lut_sel(lut_sel)
  );

  // reference model built from the requirements; pushes one item per edge
  logic [1:0]    m_hph, m_vph;
  logic [HW-1:0] m_hcnt;
  logic [VW-1:0] m_vcnt;
  logic [HW-1:0] mh [4];
  logic [VW-1:0] mv [4];
  logic m_ih, m_iv, m_ps, m_ls;

  always @(posedge clk) begin
    exp_t e;
    logic hsb, vsb, act, hend, vend;
    if (rst) begin
      m_hph = 2'd0; m_vph = 2'd0; m_hcnt = '0; m_vcnt = '0;
      mh[0] = h_sync_len; mh[1] = h_back_len; mh[2] = h_act_len; mh[3] = h_front_len;
      mv[0] = v_sync_len; mv[1] = v_back_len; mv[2] = v_act_len; mv[3] = v_front_len;
      m_ih = 0; m_iv = 0; m_ps = 0; m_ls = 0;
      e = '{rs: 1'b1, hs: ~pol_hs, vs: ~pol_vs, cs: ~pol_cs, bl: ~pol_blank,
            pe: 1'b0, x: '0, y: '0, ih: 1'b0, iv: 1'b0, ps: 1'b0, ls: 1'b0};
    end else begin
      hsb = (m_hph == 2'd0) && (m_hcnt == '0);
      vsb = hsb && (m_vph == 2'd0) && (m_vcnt == '0);
      act = (m_hph == 2'd2) && (m_vph == 2'd2);
      m_ih = (m_ih & ~ack_h) | (hsb & irq_en_h);
      m_iv = (m_iv & ~ack_v) | (vsb & irq_en_v);
      if (vsb && bank_en_page) m_ps = ~m_ps;
      if (vsb && bank_en_lut)  m_ls = ~m_ls;
      e.rs = 1'b0;
      e.hs = (m_hph == 2'd0) ? pol_hs : ~pol_hs;
      e.vs = (m_vph == 2'd0) ? pol_vs : ~pol_vs;
      e.cs = ((m_hph == 2'd0) || (m_vph == 2'd0)) ? pol_cs : ~pol_cs;
      e.bl = act ? ~pol_blank : pol_blank;
      e.pe = act;
      e.x  = (m_hph == 2'd2) ? m_hcnt : '0;
      e.y  = (m_vph == 2'd2) ? m_vcnt : '0;
      e.ih = m_ih; e.iv = m_iv; e.ps = m_ps; e.ls = m_ls;
      hend = (m_hcnt == mh[m_hph]);
      if (!hend) m_hcnt = m_hcnt + 1'b1;
      else begin
        m_hcnt = '0;
        if (m_hph == 2'd3) begin
          vend = (m_vcnt == mv[m_vph]);
          if (!vend) m_vcnt = m_vcnt + 1'b1;
          else begin
            m_vcnt = '0;
            if (m_vph == 2'd3) begin
              // R9: capture new lengths on the frame's last clock
              mh[0] = h_sync_len; mh[1] = h_back_len; mh[2] = h_act_len; mh[3] = h_front_len;
              mv[0] = v_sync_len; mv[1] = v_back_len; mv[2] = v_act_len; mv[3] = v_front_len;
            end
            m_vph = m_vph + 2'd1;
          end
        end
        m_hph = m_hph + 2'd1;
      end
    end
    q.push_back(e);
  end

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // monitor: scoreboard compare, half a clock after each edge (R10 latency)
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (e.rs) begin
        cmp("R1 reset levels", {hsync, vsync, csync, blank, pix_en},
            {e.hs, e.vs, e.cs, e.bl, e.pe});
        cmp("R1 reset counters", {pix_x, line_y}, {e.x, e.y});
        cmp("R1 reset flags", {irq_h, irq_v, page_sel, lut_sel}, {e.ih, e.iv, e.ps, e.ls});
      end else begin
        cmp("R3 hsync", hsync, e.hs);
        cmp("R3 vsync", vsync, e.vs);
        cmp("R4 csync", csync, e.cs);
        cmp("R5 blank", blank, e.bl);
        cmp("R5 pix_en", pix_en, e.pe);
        cmp("R2 pix_x", pix_x, e.x);
        cmp("R2 line_y", line_y, e.y);
        cmp("R6 irq_h", irq_h, e.ih);
        cmp("R7 irq_v", irq_v, e.iv);
        cmp("R8 page_sel", page_sel, e.ps);
        cmp("R8 lut_sel", lut_sel, e.ls);
      end
    end
  end

  // driver: run n clocks with an acknowledge pattern
  task automatic drive(input int n, input int ah, input int av);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ack_h = (ah != 0) && ((i % ah) == 0);
      ack_v = (av != 0) && ((i % av) == 0);
    end
  endtask

  task automatic set_h(input int s, input int b, input int a, input int f);
    h_sync_len = HW'(s); h_back_len = HW'(b); h_act_len = HW'(a); h_front_len = HW'(f);
  endtask

  task automatic set_v(input int s, input int b, input int a, input int f);
    v_sync_len = VW'(s); v_back_len = VW'(b); v_act_len = VW'(a); v_front_len = VW'(f);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    set_h(1, 0, 3, 0);   // 2+1+4+1 = 8 clocks per line
    set_v(0, 0, 2, 0);   // 1+1+3+1 = 6 lines per frame
    {pol_hs, pol_vs, pol_cs, pol_blank} = 4'b1111;
    irq_en_h = 1; irq_en_v = 1; ack_h = 0; ack_v = 0;
    bank_en_page = 1; bank_en_lut = 0;
    rst = 1;
    drive(3, 0, 0);          // R1 reset state
    rst = 0;
    drive(100, 0, 0);        // R6 flags set and stay set with no acknowledge
    drive(150, 7, 29);       // R7 acknowledge pattern, some edges coincide with sync
    {pol_hs, pol_vs, pol_cs, pol_blank} = 4'b0000;   // R3 R4 R5 low polarity
    bank_en_page = 0; bank_en_lut = 1;               // R8 independent flips
    irq_en_h = 0;                                    // R6 disabled source
    drive(120, 3, 5);
    {pol_hs, pol_vs, pol_cs, pol_blank} = 4'b1010;
    irq_en_h = 1; bank_en_page = 1;
    drive(21, 0, 0);
    set_h(2, 1, 5, 1);   // R9: mid-frame change, used from the next frame
    set_v(1, 0, 3, 1);
    drive(300, 11, 13);
    set_h(0, 0, 0, 0);   // R2 minimum length of one clock per interval
    set_v(0, 0, 0, 0);
    drive(200, 4, 9);
    rst = 1;             // R1 reset in mid-run
    drive(2, 0, 0);
    rst = 0;
    set_h(1, 1, 2, 0);
    drive(200, 6, 0);
    @(negedge clk);
    finish_run();
  end
endmodule